// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Decimal Adjust

This block is the byte-wide arithmetic and logic engine of an accumulator-based microcontroller core. Each cycle in which the core raises `op_valid`, the block takes a 4-bit operation code, the current accumulator byte, a second operand byte and the present carry, auxiliary-carry and overflow flags. It computes the new accumulator value and the new flags, and registers them on that clock edge. It covers binary addition with and without carry-in, subtraction with borrow, packed-BCD correction after an addition, bitwise logic, clear and complement, four rotate forms, nibble swap, a low-digit exchange that returns two modified bytes, and a plain move.

The core does the decode, the operand fetch and the write-back. It feeds the registered results back as the accumulator, flag and memory-byte inputs of later operations. Decimal correction relies on the carry and auxiliary-carry flags that the preceding addition left behind, so the block generates both flags on every arithmetic operation.

Top module: `acc_alu`

## Requirements
- R1: While `rst_n` is low, all registered outputs (`res_acc`, `res_opnd`, `res_cy`, `res_ac`, `res_ov`) are zero.
- R2: On a clock edge with `op_valid` low, every output keeps its previous value, whatever the other inputs are.
- R3: Code 0 (add) gives `res_acc` = (acc+opnd) mod 256, and code 1 (add with carry) also adds `cy_in`. `res_cy` is the carry out of bit 7, `res_ac` is the carry out of bit 3, and `res_ov` is set when both inputs have equal sign bits that differ from the sign bit of the result.
- R4: Code 2 (subtract with borrow) gives `res_acc` = (acc − opnd − cy_in) mod 256. `res_cy` is the borrow out of bit 7, `res_ac` is the borrow into bit 4, and `res_ov` is set when the inputs' sign bits differ and the result's sign bit differs from the accumulator's.
- R5: Code 3 (decimal adjust) first adds 0x06 when acc[3:0] > 9 or `ac_in` = 1. It then adds 0x60 when the high nibble of that intermediate value is > 9, when `cy_in` = 1, or when the first step carried out. `res_cy` = `cy_in` OR either carry out, so this operation never clears the carry.
- R6: Codes 4, 5 and 6 give AND, OR and XOR of acc and opnd. Code 7 gives 0x00 and code 8 gives ~acc. All five pass `cy_in`, `ac_in` and `ov_in` through unchanged.
- R7: Codes 9 and 11 rotate acc left and right by one bit without the carry, and leave `res_cy` = `cy_in`. Codes 10 and 12 rotate left and right through the 9-bit ring of carry plus accumulator.
- R8: Code 13 exchanges acc[7:4] and acc[3:0] and leaves all flags unchanged.
- R9: Code 14 (low-digit exchange) gives `res_acc` = {acc[7:4], opnd[3:0]} and `res_opnd` = {opnd[7:4], acc[3:0]}. For every other code, `res_opnd` = `opnd_in`.
- R10: Code 15 (move) loads `res_acc` with opnd and leaves all flags unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Execute the presented operation on this edge |
| op_code | input | 4 | Operation selector (codes 0 to 15) |
| acc_in | input | 8 | Current accumulator value |
| opnd_in | input | 8 | Second operand / memory byte |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary-carry flag |
| ov_in | input | 1 | Current overflow flag |
| res_acc | output | 8 | Registered new accumulator |
| res_opnd | output | 8 | Registered second byte (modified by low-digit exchange) |
| res_cy | output | 1 | Registered carry flag |
| res_ac | output | 1 | Registered auxiliary-carry flag |
| res_ov | output | 1 | Registered overflow flag |

## Verification
The hardest case is the decimal adjust in which the first (+0x06) correction carries into the high nibble and pushes it above 9. The second correction then has to be triggered by that intermediate value rather than by the original accumulator. The stimulus reaches this case by presenting 0x9A with both incoming flags clear, where the result must wrap to 0x00 with carry set. A second test presents a carry that is already set together with small digits, to show that the carry is never cleared. The signed-overflow and nibble-borrow flags are reached through operand pairs that are chosen to cross bit 3 and bit 7.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;
    localparam int NIB_W  = 4;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_DADJ = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_CLR  = 4'd7,
        OP_CPL  = 4'd8,
        OP_RL   = 4'd9,
        OP_RLC  = 4'd10,
        OP_RR   = 4'd11,
        OP_RRC  = 4'd12,
        OP_SWAP = 4'd13,
        OP_XLOW = 4'd14,
        OP_MOVE = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] opnd;
        logic              cy;
        logic              ac;
        logic              ov;
    } alu_state_t;

endpackage

// File: rtl/acc_alu_addsub.sv
// Shared adder for add, add-with-carry and subtract-with-borrow.
// Subtraction is done as a + ~b + ~borrow, and the carries are inverted into borrows.
module acc_alu_addsub #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         cout,
    output logic         hc,
    output logic         ov
);
    logic [W-1:0]   b_eff;
    logic           c_eff;
    logic [W:0]     full_sum;
    logic [NIB:0]   low_sum;

    always_comb begin
        b_eff    = sub ? ~b : b;
        c_eff    = sub ? ~cin : cin;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low_sum  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        res      = full_sum[W-1:0];
        cout     = sub ? ~full_sum[W] : full_sum[W];
        hc       = sub ? ~low_sum[NIB] : low_sum[NIB];
        ov       = (a[W-1] == b_eff[W-1]) && (full_sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/acc_alu_dadj.sv
// Packed two-digit BCD correction after a binary addition.
module acc_alu_dadj #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic         ac,
    input  logic         cy,
    output logic [W-1:0] res,
    output logic         cy_out
);
    localparam logic [NIB-1:0] DIGIT_MAX = NIB'(9);
    localparam logic [W:0]     LOW_FIX   = (W+1)'(6);
    localparam logic [W:0]     HIGH_FIX  = (W+1)'(6) << NIB;

    logic [W:0] step1;
    logic [W:0] step2;
    logic       low_hit;
    logic       high_hit;

    always_comb begin
        low_hit  = (a[NIB-1:0] > DIGIT_MAX) || ac;
        step1    = {1'b0, a} + (low_hit ? LOW_FIX : '0);
        high_hit = (step1[W-1:NIB] > DIGIT_MAX) || cy || step1[W];
        step2    = {1'b0, step1[W-1:0]} + (high_hit ? HIGH_FIX : '0);
        res      = step2[W-1:0];
        cy_out   = cy | step1[W] | step2[W];
    end
endmodule

// File: rtl/acc_alu_rot.sv
// Rotate, rotate-through-carry and nibble swap.
module acc_alu_rot #(
    parameter int W   = 8,
    parameter int NIB = 4
) (
    input  logic [W-1:0] a,
    input  logic         cy,
    output logic [W-1:0] rl,
    output logic [W-1:0] rr,
    output logic [W-1:0] rlc,
    output logic         rlc_cy,
    output logic [W-1:0] rrc,
    output logic         rrc_cy,
    output logic [W-1:0] swp
);
    always_comb begin
        rl     = {a[W-2:0], a[W-1]};
        rr     = {a[0], a[W-1:1]};
        rlc    = {a[W-2:0], cy};
        rlc_cy = a[W-1];
        rrc    = {cy, a[W-1:1]};
        rrc_cy = a[0];
        swp    = {a[NIB-1:0], a[W-1:NIB]};
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int NIB = NIB_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [W-1:0]  acc_in,
    input  logic [W-1:0]  opnd_in,
    input  logic          cy_in,
    input  logic          ac_in,
    input  logic          ov_in,
    output logic [W-1:0]  res_acc,
    output logic [W-1:0]  res_opnd,
    output logic          res_cy,
    output logic          res_ac,
    output logic          res_ov
);
    alu_state_t st_d, st_q;

    logic          as_sub;
    logic          as_cin;
    logic [W-1:0]  as_res;
    logic          as_cout, as_hc, as_ov;
    logic [W-1:0]  da_res;
    logic          da_cy;
    logic [W-1:0]  r_rl, r_rr, r_rlc, r_rrc, r_swp;
    logic          r_rlc_cy, r_rrc_cy;

    assign as_sub = (op_code == OP_SUBB);
    assign as_cin = (op_code == OP_ADD) ? 1'b0 : cy_in;

    acc_alu_addsub #(.W(W), .NIB(NIB)) addsub_i (
        .a(acc_in), .b(opnd_in), .cin(as_cin), .sub(as_sub),
        .res(as_res), .cout(as_cout), .hc(as_hc), .ov(as_ov)
    );

    acc_alu_dadj #(.W(W), .NIB(NIB)) dadj_i (
        .a(acc_in), .ac(ac_in), .cy(cy_in),
        .res(da_res), .cy_out(da_cy)
    );

    acc_alu_rot #(.W(W), .NIB(NIB)) rot_i (
        .a(acc_in), .cy(cy_in),
        .rl(r_rl), .rr(r_rr), .rlc(r_rlc), .rlc_cy(r_rlc_cy),
        .rrc(r_rrc), .rrc_cy(r_rrc_cy), .swp(r_swp)
    );

    always_comb begin
        st_d = st_q;
        if (op_valid) begin
            st_d.acc  = acc_in;
            st_d.opnd = opnd_in;
            st_d.cy   = cy_in;
            st_d.ac   = ac_in;
            st_d.ov   = ov_in;
            case (alu_op_e'(op_code))
                OP_ADD, OP_ADDC, OP_SUBB: begin
                    st_d.acc = as_res;
                    st_d.cy  = as_cout;
                    st_d.ac  = as_hc;
                    st_d.ov  = as_ov;
                end
                OP_DADJ: begin
                    st_d.acc = da_res;
                    st_d.cy  = da_cy;
                end
                OP_AND:  st_d.acc = acc_in & opnd_in;
                OP_OR:   st_d.acc = acc_in | opnd_in;
                OP_XOR:  st_d.acc = acc_in ^ opnd_in;
                OP_CLR:  st_d.acc = '0;
                OP_CPL:  st_d.acc = ~acc_in;
                OP_RL:   st_d.acc = r_rl;
                OP_RR:   st_d.acc = r_rr;
                OP_RLC: begin
                    st_d.acc = r_rlc;
                    st_d.cy  = r_rlc_cy;
                end
                OP_RRC: begin
                    st_d.acc = r_rrc;
                    st_d.cy  = r_rrc_cy;
                end
                OP_SWAP: st_d.acc = r_swp;
                OP_XLOW: begin
                    st_d.acc  = {acc_in[W-1:NIB], opnd_in[NIB-1:0]};
                    st_d.opnd = {opnd_in[W-1:NIB], acc_in[NIB-1:0]};
                end
                OP_MOVE: st_d.acc = opnd_in;
                default: st_d.acc = acc_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res_acc  = st_q.acc;
    assign res_opnd = st_q.opnd;
    assign res_cy   = st_q.cy;
    assign res_ac   = st_q.ac;
    assign res_ov   = st_q.ov;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic [W-1:0]  acc_in,
    input logic [W-1:0]  opnd_in,
    input logic          cy_in,
    input logic          ac_in,
    input logic          ov_in,
    input logic [W-1:0]  res_acc,
    input logic [W-1:0]  res_opnd,
    input logic          res_cy,
    input logic          res_ac,
    input logic          res_ov
);
    localparam int H = W / 2;

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(res_acc) && $stable(res_opnd) && $stable(res_cy)
                      && $stable(res_ac) && $stable(res_ov));

    assert_add_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0) |=>
            {res_cy, res_acc} == ({1'b0, $past(acc_in)} + {1'b0, $past(opnd_in)}));

    assert_dadj_keeps_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd3 && cy_in) |=> res_cy);

    assert_logic_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd4 && op_code <= 4'd8) |=>
            res_cy == $past(cy_in) && res_ac == $past(ac_in) && res_ov == $past(ov_in));

    assert_swap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd13) |=>
            res_acc == {$past(acc_in[H-1:0]), $past(acc_in[W-1:H])});

    assert_xlow_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd14) |=>
            res_acc[W-1:H] == $past(acc_in[W-1:H]) && res_opnd[W-1:H] == $past(opnd_in[W-1:H]));

    assert_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd15) |=> res_acc == $past(opnd_in));
endmodule

bind acc_alu acc_alu_chk #(.W(W)) chk_i (.*);

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [7:0] acc_in = '0, opnd_in = '0;
    logic       cy_in = 1'b0, ac_in = 1'b0, ov_in = 1'b0;
    logic [7:0] res_acc, res_opnd;
    logic       res_cy, res_ac, res_ov;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    acc_alu dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .acc_in(acc_in), .opnd_in(opnd_in), .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
        .res_acc(res_acc), .res_opnd(res_opnd), .res_cy(res_cy), .res_ac(res_ac), .res_ov(res_ov)
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // Presents one operation, lets it register, and returns at the following falling edge.
    task automatic run_op(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                          input logic c, input logic h, input logic v);
        @(negedge clk);
        op_code = op; acc_in = a; opnd_in = b; cy_in = c; ac_in = h; ov_in = v;
        op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic expect_all(input string tag, input logic [7:0] ea, input logic [7:0] eo,
                              input logic ec, input logic eh, input logic ev);
        check({tag, " acc"}, res_acc, ea);
        check({tag, " opnd"}, res_opnd, eo);
        check({tag, " cy"}, {7'd0, res_cy}, {7'd0, ec});
        check({tag, " ac"}, {7'd0, res_ac}, {7'd0, eh});
        check({tag, " ov"}, {7'd0, res_ov}, {7'd0, ev});
    endtask

    task automatic t_reset_R1;
        op_valid = 1'b1; op_code = 4'd15; opnd_in = 8'hFF;
        repeat (3) @(negedge clk);
        expect_all("R1 reset", 8'h00, 8'h00, 1'b0, 1'b0, 1'b0);
        op_valid = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic t_add_R3;
        run_op(4'd0, 8'h44, 8'hCA, 1'b1, 1'b1, 1'b1);
        expect_all("R3 add low", 8'h0E, 8'hCA, 1'b1, 1'b0, 1'b0);
        run_op(4'd1, 8'h1E, 8'h56, 1'b1, 1'b0, 1'b0);
        expect_all("R3 addc high", 8'h75, 8'h56, 1'b0, 1'b1, 1'b0);
        run_op(4'd0, 8'h7F, 8'h01, 1'b0, 1'b0, 1'b0);
        expect_all("R3 add ovf", 8'h80, 8'h01, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_subb_R4;
        run_op(4'd2, 8'h50, 8'h20, 1'b0, 1'b1, 1'b1);
        expect_all("R4 subb plain", 8'h30, 8'h20, 1'b0, 1'b0, 1'b0);
        run_op(4'd2, 8'h10, 8'h20, 1'b1, 1'b0, 1'b0);
        expect_all("R4 subb borrow", 8'hEF, 8'h20, 1'b1, 1'b1, 1'b0);
        run_op(4'd2, 8'h80, 8'h01, 1'b0, 1'b0, 1'b0);
        expect_all("R4 subb ovf", 8'h7F, 8'h01, 1'b0, 1'b1, 1'b1);
    endtask

    task automatic t_dadj_R5;
        run_op(4'd0, 8'h34, 8'h49, 1'b0, 1'b0, 1'b0);
        expect_all("R5 pre-add", 8'h7D, 8'h49, 1'b0, 1'b0, 1'b0);
        run_op(4'd3, res_acc, 8'h00, res_cy, res_ac, res_ov);
        expect_all("R5 adjust 7D", 8'h83, 8'h00, 1'b0, 1'b0, 1'b0);
        run_op(4'd3, 8'h9A, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_all("R5 adjust 9A", 8'h00, 8'h00, 1'b1, 1'b0, 1'b0);
        run_op(4'd3, 8'h12, 8'h00, 1'b1, 1'b1, 1'b0);
        expect_all("R5 adjust ac+cy", 8'h78, 8'h00, 1'b1, 1'b1, 1'b0);
        run_op(4'd3, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1);
        expect_all("R5 adjust cy only", 8'h60, 8'h00, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_logic_R6;
        run_op(4'd4, 8'hF0, 8'h3C, 1'b1, 1'b1, 1'b0);
        expect_all("R6 and", 8'h30, 8'h3C, 1'b1, 1'b1, 1'b0);
        run_op(4'd5, 8'h0F, 8'hA0, 1'b0, 1'b1, 1'b1);
        expect_all("R6 or", 8'hAF, 8'hA0, 1'b0, 1'b1, 1'b1);
        run_op(4'd6, 8'hFF, 8'h5A, 1'b1, 1'b0, 1'b1);
        expect_all("R6 xor", 8'hA5, 8'h5A, 1'b1, 1'b0, 1'b1);
        run_op(4'd7, 8'hC3, 8'h11, 1'b1, 1'b1, 1'b1);
        expect_all("R6 clr", 8'h00, 8'h11, 1'b1, 1'b1, 1'b1);
        run_op(4'd8, 8'h5A, 8'h22, 1'b0, 1'b0, 1'b0);
        expect_all("R6 cpl", 8'hA5, 8'h22, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_rot_R7;
        run_op(4'd9, 8'h81, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_all("R7 rl", 8'h03, 8'h00, 1'b0, 1'b0, 1'b0);
        run_op(4'd11, 8'h81, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R7 rr", 8'hC0, 8'h00, 1'b1, 1'b0, 1'b0);
        run_op(4'd10, 8'h81, 8'h00, 1'b0, 1'b0, 1'b0);
        expect_all("R7 rlc", 8'h02, 8'h00, 1'b1, 1'b0, 1'b0);
        run_op(4'd12, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R7 rrc set", 8'h80, 8'h00, 1'b1, 1'b0, 1'b0);
        run_op(4'd12, 8'h02, 8'h00, 1'b1, 1'b0, 1'b0);
        expect_all("R7 rrc clr", 8'h81, 8'h00, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_swap_R8;
        run_op(4'd13, 8'h3C, 8'h77, 1'b1, 1'b0, 1'b1);
        expect_all("R8 swap", 8'hC3, 8'h77, 1'b1, 1'b0, 1'b1);
    endtask

    task automatic t_xlow_R9;
        run_op(4'd14, 8'h12, 8'hAB, 1'b0, 1'b1, 1'b0);
        expect_all("R9 xlow", 8'h1B, 8'hA2, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_move_R10;
        run_op(4'd15, 8'h00, 8'h77, 1'b1, 1'b1, 1'b0);
        expect_all("R10 move", 8'h77, 8'h77, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_hold_R2;
        run_op(4'd0, 8'h01, 8'h02, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        op_code = 4'd8; acc_in = 8'hF0; opnd_in = 8'h0F; cy_in = 1'b1; ac_in = 1'b1; ov_in = 1'b1;
        repeat (2) @(negedge clk);
        expect_all("R2 hold", 8'h03, 8'h02, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        t_reset_R1;
        t_add_R3;
        t_subb_R4;
        t_dadj_R5;
        t_logic_R6;
        t_rot_R7;
        t_swap_R8;
        t_xlow_R9;
        t_move_R10;
        t_hold_R2;
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule